// File: doc/BRIEF.md
# Integer Shift and Rotate Unit

A single-cycle-latency execution unit for a 32-bit integer pipeline that performs logical left shift, logical right shift, arithmetic right shift and right rotate. The pipeline hands it an already split instruction: the 6-bit function code, the four 5-bit register and shift-amount fields, and the two source operand values. The unit picks the operation and the amount source, runs a logarithmic barrel network and registers the result together with a one-cycle `valid_o` pulse.

Each operation has an immediate form, where the amount comes from the sa field, and a variable form, where it comes from the low five bits of the rs operand value. Right rotate has no function code of its own. In the immediate form it is picked by bit 0 of the rs field, and in the variable form by bit 0 of the sa field. The unit also classifies the all-zero left-shift encodings as no-operation hints, and it flags malformed or unsupported encodings as reserved.

Top module: `shift_unit`

## Requirements
- R1: Function code 0 with rs field 0, and with rt field or rd field nonzero, gives `result_o` = rt value shifted left by sa, with zero fill.
- R2: Function code 0 with the rs, rt and rd fields all 0 is a hint. `hint_o` is 2 for sa=1, 3 for sa=3 and 1 for any other sa. In every case `result_o` is 0 and `rsvd_o` is 0. For any non-hint instruction, `hint_o` is 0.
- R3: Function code 2 with rs field 0 gives a logical right shift of rt by sa, with zero fill.
- R4: Function code 2 with rs field 1 gives a right rotate of rt by sa. Bits shifted out at bit 0 re-enter at bit 31.
- R5: Function code 3 with rs field 0 gives an arithmetic right shift of rt by sa. Every vacated high bit equals bit 31 of rt.
- R6: Function codes 4, 6 and 7 are the variable left shift, right shift and arithmetic right shift. The amount is bits 4:0 of the rs operand value, and its upper bits are ignored. For code 6, sa bit 0 set selects right rotate instead of right shift.
- R7: An amount of 0 returns the rt value unchanged for every operation, including rotate.
- R8: A nonzero rs field on codes 0 or 3, rs field bits 4:1 nonzero on code 2, or any function code outside {0,2,3,4,6,7} sets `rsvd_o`=1 with `result_o`=0.
- R9: Outputs update on the clock edge after `valid_i` is sampled high, and `valid_o` is high for exactly that cycle. With `valid_i` low, `valid_o` is 0 and the other outputs hold their values.
- R10: During reset, `valid_o`, `result_o`, `rsvd_o` and `hint_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction presented this cycle |
| funct_i | input | 6 | Function code |
| rs_field_i | input | 5 | rs instruction field |
| rt_field_i | input | 5 | rt instruction field |
| rd_field_i | input | 5 | rd instruction field |
| sa_i | input | 5 | sa instruction field |
| rs_val_i | input | 32 | rs operand value |
| rt_val_i | input | 32 | rt operand value |
| valid_o | output | 1 | Result valid pulse |
| result_o | output | 32 | rd result |
| rsvd_o | output | 1 | Reserved encoding flag |
| hint_o | output | 2 | 0 none, 1 NOP, 2 SSNOP, 3 EHB |

## Verification
The result register is the only state in the datapath, so any fault in the network or in the decode shows at `result_o` on the cycle after the instruction is presented. Because of that, each vector is checked on the following cycle. A barrel stage that is mis-wired only corrupts results whose amount has that stage's bit set, and the wrong fill choice only shows when bit 31 of rt is set. For this reason the sweeps cover all 32 amounts with random operands whose sign varies. A stuck valid or hold path appears as a `valid_o` that persists, or a result that changes during an idle cycle.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int FIELD_W = 5;
  localparam int FUNCT_W = 6;

  localparam logic [FUNCT_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FUNCT_W-1:0] FN_SRL  = 6'd2;
  localparam logic [FUNCT_W-1:0] FN_SRA  = 6'd3;
  localparam logic [FUNCT_W-1:0] FN_SLLV = 6'd4;
  localparam logic [FUNCT_W-1:0] FN_SRLV = 6'd6;
  localparam logic [FUNCT_W-1:0] FN_SRAV = 6'd7;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SLL,
    OP_SRL,
    OP_SRA,
    OP_ROR
  } shift_op_e;

  typedef enum logic [1:0] {
    HINT_NONE  = 2'd0,
    HINT_NOP   = 2'd1,
    HINT_SSNOP = 2'd2,
    HINT_EHB   = 2'd3
  } hint_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [FIELD_W-1:0] rs_field_i,
  input  logic [FIELD_W-1:0] rt_field_i,
  input  logic [FIELD_W-1:0] rd_field_i,
  input  logic [FIELD_W-1:0] sa_i,
  input  logic [AMT_W-1:0]   rs_amt_i,
  output shift_op_e          op_o,
  output logic [AMT_W-1:0]   amt_o,
  output logic               rsvd_o,
  output hint_e              hint_o
);
  logic [AMT_W-1:0] sa_amt;
  assign sa_amt = AMT_W'(sa_i);

  always_comb begin
    op_o   = OP_NONE;
    amt_o  = '0;
    rsvd_o = 1'b0;
    hint_o = HINT_NONE;
    unique case (funct_i)
      FN_SLL: begin
        if (rs_field_i != '0) begin
          rsvd_o = 1'b1;
        end else if (rt_field_i == '0 && rd_field_i == '0) begin
          unique case (sa_i)
            5'd1:    hint_o = HINT_SSNOP;
            5'd3:    hint_o = HINT_EHB;
            default: hint_o = HINT_NOP;
          endcase
        end else begin
          op_o  = OP_SLL;
          amt_o = sa_amt;
        end
      end
      FN_SRL: begin
        // bit 0 of rs field picks rotate
        if (rs_field_i[FIELD_W-1:1] != '0) begin
          rsvd_o = 1'b1;
        end else begin
          op_o  = rs_field_i[0] ? OP_ROR : OP_SRL;
          amt_o = sa_amt;
        end
      end
      FN_SRA: begin
        if (rs_field_i != '0) rsvd_o = 1'b1;
        else begin
          op_o  = OP_SRA;
          amt_o = sa_amt;
        end
      end
      FN_SLLV: begin
        op_o  = OP_SLL;
        amt_o = rs_amt_i;
      end
      FN_SRLV: begin
        // bit 0 of sa field picks rotate
        op_o  = sa_i[0] ? OP_ROR : OP_SRL;
        amt_o = rs_amt_i;
      end
      FN_SRAV: begin
        op_o  = OP_SRA;
        amt_o = rs_amt_i;
      end
      default: rsvd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  input  logic              rotate_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rev_in, pre, post, rev_out;
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic              fill;

  // left shift = reverse, right shift, reverse
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = data_i[DATA_W-1-i];
    assign rev_out[i] = post[DATA_W-1-i];
  end

  assign pre      = left_i ? rev_in : data_i;
  assign fill     = arith_i & ~left_i & data_i[DATA_W-1];
  assign stage[0] = pre;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] top_bits;
    assign top_bits   = rotate_i ? stage[k][S-1:0] : {S{fill}};
    assign stage[k+1] = amt_i[k] ? {top_bits, stage[k][DATA_W-1:S]} : stage[k];
  end

  assign post   = stage[AMT_W];
  assign data_o = left_i ? rev_out : post;
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [5:0]        funct_i,
  input  logic [4:0]        rs_field_i,
  input  logic [4:0]        rt_field_i,
  input  logic [4:0]        rd_field_i,
  input  logic [4:0]        sa_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              rsvd_o,
  output logic [1:0]        hint_o
);
  localparam int AMT_W = $clog2(DATA_W);

  shift_op_e         op_d;
  logic [AMT_W-1:0]  amt_d;
  logic              rsvd_d;
  hint_e             hint_d;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] result_d;

  shift_decode #(.AMT_W(AMT_W)) u_decode (
    .funct_i   (funct_i),
    .rs_field_i(rs_field_i),
    .rt_field_i(rt_field_i),
    .rd_field_i(rd_field_i),
    .sa_i      (sa_i),
    .rs_amt_i  (rs_val_i[AMT_W-1:0]),
    .op_o      (op_d),
    .amt_o     (amt_d),
    .rsvd_o    (rsvd_d),
    .hint_o    (hint_d)
  );

  shift_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .data_i  (rt_val_i),
    .amt_i   (amt_d),
    .left_i  (op_d == OP_SLL),
    .arith_i (op_d == OP_SRA),
    .rotate_i(op_d == OP_ROR),
    .data_o  (shifted)
  );

  assign result_d = (op_d == OP_NONE) ? '0 : shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      rsvd_o   <= 1'b0;
      hint_o   <= HINT_NONE;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= result_d;
        rsvd_o   <= rsvd_d;
        hint_o   <= hint_d;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(rsvd_o) && $stable(hint_o)));
  // R7
  zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_d != OP_NONE && amt_d == '0) |=> result_o == $past(rt_val_i));
  // R5
  sign_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_d == OP_SRA && rt_val_i[DATA_W-1]) |=> result_o[DATA_W-1]);
  // R8
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rsvd_o) |-> (result_o == '0 && hint_o == HINT_NONE));
  // R2
  hint_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hint_o != HINT_NONE) |-> (result_o == '0 && !rsvd_o));
endmodule

// File: tb/tb_shift_unit.sv
module tb_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  funct_i = '0;
  logic [4:0]  rs_field_i = '0, rt_field_i = '0, rd_field_i = '0, sa_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0;
  logic        valid_o, rsvd_o;
  logic [31:0] result_o;
  logic [1:0]  hint_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  shift_unit dut (
    .clk_i, .rst_ni, .valid_i, .funct_i, .rs_field_i, .rt_field_i, .rd_field_i,
    .sa_i, .rs_val_i, .rt_val_i, .valid_o, .result_o, .rsvd_o, .hint_o
  );

  function automatic logic [31:0] ref_sll(logic [31:0] v, int a); return v << a; endfunction
  function automatic logic [31:0] ref_srl(logic [31:0] v, int a); return v >> a; endfunction
  function automatic logic [31:0] ref_sra(logic [31:0] v, int a);
    return 32'($signed(v) >>> a);
  endfunction
  function automatic logic [31:0] ref_ror(logic [31:0] v, int a);
    logic [63:0] w = {v, v};
    return w[a +: 32];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] fn, logic [4:0] rsf, logic [4:0] rtf, logic [4:0] rdf,
                       logic [4:0] sa, logic [31:0] rsv, logic [31:0] rtv);
    @(negedge clk_i);
    valid_i = 1'b1; funct_i = fn; rs_field_i = rsf; rt_field_i = rtf;
    rd_field_i = rdf; sa_i = sa; rs_val_i = rsv; rt_val_i = rtv;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic expect_out(string req, logic [31:0] exp, logic rsvd, logic [1:0] hint);
    check(req, {31'd0, valid_o}, 32'd1);
    check(req, result_o, exp);
    check(req, {31'd0, rsvd_o}, {31'd0, rsvd});
    check(req, {30'd0, hint_o}, {30'd0, hint});
  endtask

  task automatic t_reset();
    check("R10", {31'd0, valid_o}, 32'd0);
    check("R10", result_o, 32'd0);
    check("R10", {31'd0, rsvd_o}, 32'd0);
    check("R10", {30'd0, hint_o}, 32'd0);
  endtask

  task automatic t_imm_sweep();
    for (int a = 0; a < 32; a++) begin
      logic [31:0] v = $urandom;
      if (a % 2 == 1) v[31] = 1'b1;
      apply(6'd0, 5'd0, 5'd3, 5'd4, 5'(a), 32'd0, v);
      expect_out("R1 sll", ref_sll(v, a), 1'b0, 2'd0);
      apply(6'd2, 5'd0, 5'd3, 5'd4, 5'(a), 32'd0, v);
      expect_out("R3 srl", ref_srl(v, a), 1'b0, 2'd0);
      apply(6'd2, 5'd1, 5'd3, 5'd4, 5'(a), 32'd0, v);
      expect_out("R4 rotr", ref_ror(v, a), 1'b0, 2'd0);
      apply(6'd3, 5'd0, 5'd3, 5'd4, 5'(a), 32'd0, v);
      expect_out("R5 sra", ref_sra(v, a), 1'b0, 2'd0);
    end
  endtask

  task automatic t_var_sweep();
    for (int a = 0; a < 32; a++) begin
      logic [31:0] v = $urandom;
      logic [31:0] r = {$urandom, 5'(a)};
      if (a % 3 == 0) v[31] = 1'b1;
      apply(6'd4, 5'd7, 5'd3, 5'd4, 5'd30, r, v);
      expect_out("R6 sllv", ref_sll(v, a), 1'b0, 2'd0);
      apply(6'd6, 5'd7, 5'd3, 5'd4, 5'd0, r, v);
      expect_out("R6 srlv", ref_srl(v, a), 1'b0, 2'd0);
      apply(6'd6, 5'd7, 5'd3, 5'd4, 5'd1, r, v);
      expect_out("R6 rotrv", ref_ror(v, a), 1'b0, 2'd0);
      apply(6'd7, 5'd7, 5'd3, 5'd4, 5'd9, r, v);
      expect_out("R6 srav", ref_sra(v, a), 1'b0, 2'd0);
    end
  endtask

  task automatic t_zero_amt();
    logic [31:0] v = 32'h8765_4321;
    apply(6'd2, 5'd1, 5'd1, 5'd1, 5'd0, 32'd0, v);
    expect_out("R7 rotr0", v, 1'b0, 2'd0);
    apply(6'd6, 5'd0, 5'd1, 5'd1, 5'd1, 32'hFFFF_FFE0, v);
    expect_out("R7 rotrv0", v, 1'b0, 2'd0);
    apply(6'd3, 5'd0, 5'd1, 5'd1, 5'd0, 32'd0, v);
    expect_out("R7 sra0", v, 1'b0, 2'd0);
  endtask

  task automatic t_hints();
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd0, 32'd5, 32'hFFFF_FFFF);
    expect_out("R2 nop", 32'd0, 1'b0, 2'd1);
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd1, 32'd5, 32'hFFFF_FFFF);
    expect_out("R2 ssnop", 32'd0, 1'b0, 2'd2);
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd3, 32'd5, 32'hFFFF_FFFF);
    expect_out("R2 ehb", 32'd0, 1'b0, 2'd3);
    apply(6'd0, 5'd0, 5'd0, 5'd0, 5'd7, 32'd5, 32'hFFFF_FFFF);
    expect_out("R2 nop sa7", 32'd0, 1'b0, 2'd1);
    apply(6'd0, 5'd0, 5'd0, 5'd2, 5'd3, 32'd0, 32'h0000_0001);
    expect_out("R1 not hint", 32'h0000_0008, 1'b0, 2'd0);
  endtask

  task automatic t_reserved();
    apply(6'd0, 5'd4, 5'd1, 5'd1, 5'd2, 32'd0, 32'h1234_5678);
    expect_out("R8 sll rs", 32'd0, 1'b1, 2'd0);
    apply(6'd0, 5'd4, 5'd0, 5'd0, 5'd1, 32'd0, 32'h1234_5678);
    expect_out("R8 hint rs", 32'd0, 1'b1, 2'd0);
    apply(6'd2, 5'd2, 5'd1, 5'd1, 5'd2, 32'd0, 32'h1234_5678);
    expect_out("R8 srl rs", 32'd0, 1'b1, 2'd0);
    apply(6'd3, 5'd1, 5'd1, 5'd1, 5'd2, 32'd0, 32'h8234_5678);
    expect_out("R8 sra rs", 32'd0, 1'b1, 2'd0);
    apply(6'd1, 5'd0, 5'd1, 5'd1, 5'd2, 32'd3, 32'h1234_5678);
    expect_out("R8 fn1", 32'd0, 1'b1, 2'd0);
    apply(6'd5, 5'd0, 5'd1, 5'd1, 5'd2, 32'd3, 32'h1234_5678);
    expect_out("R8 fn5", 32'd0, 1'b1, 2'd0);
    apply(6'd32, 5'd0, 5'd1, 5'd1, 5'd2, 32'd3, 32'h1234_5678);
    expect_out("R8 fn32", 32'd0, 1'b1, 2'd0);
  endtask

  task automatic t_hold();
    apply(6'd2, 5'd0, 5'd1, 5'd1, 5'd4, 32'd0, 32'hABCD_0000);
    expect_out("R9 latency", 32'h0ABC_D000, 1'b0, 2'd0);
    @(negedge clk_i);
    valid_i = 1'b0; funct_i = 6'd1; rt_val_i = 32'hFFFF_FFFF; sa_i = 5'd0;
    @(negedge clk_i);
    check("R9 idle valid", {31'd0, valid_o}, 32'd0);
    check("R9 idle hold", result_o, 32'h0ABC_D000);
    check("R9 idle rsvd", {31'd0, rsvd_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_imm_sweep();
    t_var_sweep();
    t_zero_amt();
    t_hints();
    t_reserved();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule